// File: doc/BRIEF.md
# Feedback-Type Secure Scan Register

This block is a scan segment of K flip-flops that takes the place of the part of a scan chain holding secret state. In functional mode every stage captures its parallel input through the usual capture/shift multiplexer. In scan mode the stages shift from the serial input toward the serial output. Selected stage inputs are XOR gates that also receive a product term, an AND of chosen bits of the present register state. The XOR network sits only on the shift path, so the functional capture path has no added logic.

The feedback terms of a stage may use only that stage and the stages downstream of it. With that rule, the serial output K cycles later equals the input bit XORed with a fixed function of the state. The starting state can be recovered from K output bits alone, whatever is being shifted in. Loading a chosen state, on the other hand, needs the starting state to be known, because the inputs that reach a target depend on it.

Two build options harden the segment. The first adds an inverter between the serial input and the first stage, optionally with an extra leading flip-flop. The second adds an inverter on the serial output. With these options, the bit stream seen on either scan pin never matches that of a plain shift register.

Top module: `gfsr_secure_scan`

## Requirements
- R1: While `rstN` is low the register (and the leading flip-flop, if present) clears to zero, so `stateOut` reads 0 and `scanOut` reads the output-inverter setting (0 plain, 1 hardened).
- R2: With `scanEn` low, every stage loads `capData` on the rising edge without any XOR term applied (`stateOut[i]` = `capData[i]`, bit 0 is the stage nearest the input).
- R3: With `scanEn` high, stage 0 loads the head bit, and stage i>0 loads stage i-1. A stage whose `XOR_MASK` bit is set also XORs in the AND of the state bits selected by its `K`-bit slice of `TERM_MASK`. In the default 3-stage build that gives y1'=x, y2'=y1 XOR y2·y3, y3'=y2.
- R4: `scanOut` equals the last stage, inverted when the output inverter is enabled.
- R5: In the default build, the serial output three shifts after time t equals x(t) XOR y1(t)·y2(t) XOR y2(t)·y3(t).
- R6: In the default build, the state at time t follows from three consecutive outputs alone: y3=z(t), y2=z(t+1), y1=z(t+2) XOR z(t+1)·z(t), for any shifted-in bits.
- R7: From a known state y, the default build reaches a target (a1,a2,a3) after shifting x0=a3⊕y1y2⊕y2y3, then x1=a2⊕a3·(y1⊕y2y3), then x2=a1.
- R8: With both inverters enabled, an all-zero state unloads as ones and shifting zeros in from reset loads ones, so neither stream matches a plain shift register.
- R9: When the leading flip-flop is enabled, a serial input bit reaches stage 0 after two shifts instead of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanEn | input | 1 | 1 selects shift, 0 selects parallel capture |
| scanIn | input | 1 | Serial scan data in |
| capData | input | K | Parallel functional data captured when not shifting |
| stateOut | output | K | Present register state, bit 0 nearest the input |
| scanOut | output | 1 | Serial scan data out |

## Verification
The bench goes after the nonlinear shift step. It captures random states, shifts random bits and compares the output three shifts later against the product-term equation. A design that left out a feedback term, or fed it from the wrong stages, passes plain-shift tests but breaks that equation and the state recovery from outputs. The bench also loads random targets using input bits computed from the known start state, which catches a term applied on the wrong cycle. A hardened copy shows inverted bits on both scan pins and a one-shift delay from the leading flip-flop; a missing inverter or a bypassed extra stage would give back the plain shift-register stream.

// File: rtl/gfsr_pkg.sv
package gfsr_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic shift;
    logic capture;
  } gfsrStrobe_t;
endpackage

// File: rtl/gfsr_ctrl.sv
module gfsr_ctrl
  import gfsr_pkg::*;
(
  input  logic        scanEn,
  output gfsrStrobe_t strobe
);
  // capture has priority: the functional path never sees the XOR network
  always_comb begin
    strobe.capture = ~scanEn;
    strobe.shift   = scanEn;
  end
endmodule

// File: rtl/gfsr_feedback.sv
module gfsr_feedback #(
  parameter int               K         = 3,
  parameter logic [K*K-1:0]   TERM_MASK = '0
) (
  input  logic [K-1:0] stg,
  output logic [K-1:0] term
);
  // one product term per stage, AND of selected state bits
  for (genvar i = 0; i < K; i++) begin : g_term
    localparam logic [K-1:0] SEL = TERM_MASK[i*K +: K];
    if (SEL == '0) begin : g_none
      assign term[i] = 1'b0;
    end else begin : g_and
      assign term[i] = &(stg | ~SEL);
    end
  end
endmodule

// File: rtl/gfsr_datapath.sv
module gfsr_datapath
  import gfsr_pkg::*;
#(
  parameter int           K        = 3,
  parameter logic [K-1:0] XOR_MASK = '0,
  parameter bit           INV_IN   = 1'b0,
  parameter bit           INV_OUT  = 1'b0,
  parameter bit           DUMMY    = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  gfsrStrobe_t strobe,
  input  logic        scanIn,
  input  logic [K-1:0] capData,
  input  logic [K-1:0] term,
  output logic [K-1:0] stg,
  output logic        scanOut
);
  logic headBit;
  logic inBit;
  logic [K-1:0] shiftNext;

  assign inBit = scanIn ^ INV_IN;

  if (DUMMY) begin : g_dummy
    logic dummyQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            dummyQ <= 1'b0;
      else if (strobe.shift) dummyQ <= inBit;
    end
    assign headBit = dummyQ;
  end else begin : g_direct
    assign headBit = inBit;
  end

  for (genvar i = 0; i < K; i++) begin : g_stage
    logic src;
    if (i == 0) begin : g_head
      assign src = headBit;
    end else begin : g_link
      assign src = stg[i-1];
    end
    if (XOR_MASK[i]) begin : g_xor
      assign shiftNext[i] = src ^ term[i];
    end else begin : g_wire
      assign shiftNext[i] = src;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stg <= '0;
    else if (strobe.capture) stg <= capData;
    else if (strobe.shift)   stg <= shiftNext;
  end

  assign scanOut = stg[K-1] ^ INV_OUT;
endmodule

// File: rtl/gfsr_secure_scan.sv
module gfsr_secure_scan
  import gfsr_pkg::*;
#(
  parameter int             K         = 3,
  parameter logic [K-1:0]   XOR_MASK  = 3'b010,
  parameter logic [K*K-1:0] TERM_MASK = 9'b000_110_000,
  parameter bit             INV_IN    = 1'b0,
  parameter bit             INV_OUT   = 1'b0,
  parameter bit             DUMMY     = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         scanEn,
  input  logic         scanIn,
  input  logic [K-1:0] capData,
  output logic [K-1:0] stateOut,
  output logic         scanOut
);
  gfsrStrobe_t strobe;
  logic [K-1:0] term;

  gfsr_ctrl u_ctrl (
    .scanEn (scanEn),
    .strobe (strobe)
  );

  gfsr_feedback #(.K(K), .TERM_MASK(TERM_MASK)) u_fb (
    .stg  (stateOut),
    .term (term)
  );

  gfsr_datapath #(
    .K(K), .XOR_MASK(XOR_MASK), .INV_IN(INV_IN), .INV_OUT(INV_OUT), .DUMMY(DUMMY)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .scanIn  (scanIn),
    .capData (capData),
    .term    (term),
    .stg     (stateOut),
    .scanOut (scanOut)
  );
endmodule

// File: rtl/gfsr_secure_scan_chk.sv
module gfsr_secure_scan_chk #(
  parameter int           K        = 3,
  parameter logic [K-1:0] XOR_MASK = '0,
  parameter bit           INV_IN   = 1'b0,
  parameter bit           INV_OUT  = 1'b0,
  parameter bit           DUMMY    = 1'b0
) (
  input logic         clk,
  input logic         rstN,
  input logic         scanEn,
  input logic         scanIn,
  input logic [K-1:0] capData,
  input logic [K-1:0] stateOut,
  input logic         scanOut
);
  p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    !scanEn |=> stateOut == $past(capData));

  p_out_r4: assert property (@(posedge clk) disable iff (!rstN)
    scanOut == (stateOut[K-1] ^ INV_OUT));

  if (!XOR_MASK[0] && !DUMMY) begin : g_head_direct
    p_head_r3: assert property (@(posedge clk) disable iff (!rstN)
      scanEn |=> stateOut[0] == ($past(scanIn) ^ INV_IN));
  end
  if (!XOR_MASK[0] && DUMMY) begin : g_head_dummy
    p_head_delay_r9: assert property (@(posedge clk) disable iff (!rstN)
      scanEn ##1 scanEn |=> stateOut[0] == ($past(scanIn, 2) ^ INV_IN));
  end

  for (genvar i = 1; i < K; i++) begin : g_pass
    if (!XOR_MASK[i]) begin : g_plain
      p_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
        scanEn |=> stateOut[i] == $past(stateOut[i-1]));
    end
  end
endmodule

bind gfsr_secure_scan gfsr_secure_scan_chk #(
  .K(K), .XOR_MASK(XOR_MASK), .INV_IN(INV_IN), .INV_OUT(INV_OUT), .DUMMY(DUMMY)
) u_chk (
  .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn),
  .capData(capData), .stateOut(stateOut), .scanOut(scanOut)
);

// File: tb/tb_gfsr_secure_scan.sv
`timescale 1ns/1ps
module tb_gfsr_secure_scan;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanEn = 1'b0, scanIn = 1'b0;
  logic [2:0] capData = '0;
  logic [2:0] stateOut;
  logic scanOut;
  logic hScanEn = 1'b0, hScanIn = 1'b0;
  logic [2:0] hCapData = '0;
  logic [2:0] hStateOut;
  logic hScanOut;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gfsr_secure_scan dut (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn),
    .capData(capData), .stateOut(stateOut), .scanOut(scanOut)
  );

  gfsr_secure_scan #(.INV_IN(1'b1), .INV_OUT(1'b1), .DUMMY(1'b1)) hdut (
    .clk(clk), .rstN(rstN), .scanEn(hScanEn), .scanIn(hScanIn),
    .capData(hCapData), .stateOut(hStateOut), .scanOut(hScanOut)
  );

  task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge, results read one falling edge later
  task automatic cap(logic [2:0] v);
    scanEn = 1'b0; capData = v;
    @(negedge clk);
  endtask

  task automatic shift(logic b);
    scanEn = 1'b1; scanIn = b;
    @(negedge clk);
    scanEn = 1'b0;
  endtask

  task automatic hshift(logic b);
    hScanEn = 1'b1; hScanIn = b;
    @(negedge clk);
    hScanEn = 1'b0;
  endtask

  task automatic test_reset();
    expect_eq("R1 state", stateOut, 0);
    expect_eq("R1 scanOut", scanOut, 0);
    expect_eq("R1 hardened state", hStateOut, 0);
    expect_eq("R1 hardened scanOut", hScanOut, 1);
  endtask

  task automatic test_capture();
    for (int v = 0; v < 8; v++) begin
      cap(3'(v));
      expect_eq("R2 capture", stateOut, v);
      expect_eq("R4 scanOut is last stage", scanOut, (v >> 2) & 1);
    end
  endtask

  task automatic test_step();
    for (int v = 0; v < 8; v++) begin
      for (int b = 0; b < 2; b++) begin
        logic [2:0] e;
        cap(3'(v));
        shift(b[0]);
        e[0] = b[0];
        e[1] = v[0] ^ (v[1] & v[2]);
        e[2] = v[1];
        expect_eq("R3 shift step", stateOut, e);
      end
    end
  endtask

  task automatic test_equation();
    for (int n = 0; n < 24; n++) begin
      logic [2:0] s, x;
      logic z0, z1, z2;
      logic [2:0] rec;
      s = 3'($urandom); x = 3'($urandom);
      cap(s);
      z0 = scanOut; shift(x[0]);
      z1 = scanOut; shift(x[1]);
      z2 = scanOut; shift(x[2]);
      rec = {z0, z1, z2 ^ (z1 & z0)};
      expect_eq("R6 state recovered from outputs", rec, s);
      expect_eq("R5 output equation", scanOut,
                x[0] ^ (s[0] & s[1]) ^ (s[1] & s[2]));
    end
  endtask

  task automatic test_load();
    for (int n = 0; n < 16; n++) begin
      logic [2:0] s, a;
      logic x0, x1, x2;
      s = 3'($urandom); a = 3'($urandom);
      x0 = a[2] ^ (s[0] & s[1]) ^ (s[1] & s[2]);
      x1 = a[1] ^ (a[2] & (s[0] ^ (s[1] & s[2])));
      x2 = a[0];
      cap(s);
      shift(x0); shift(x1); shift(x2);
      expect_eq("R7 target loaded", stateOut, a);
    end
  endtask

  task automatic test_hardened();
    hScanEn = 1'b0; hCapData = 3'b000;
    @(negedge clk);
    expect_eq("R8 zero state unloads as one", hScanOut, 1);
    hshift(1'b0);
    expect_eq("R8 first zero unload bit", hScanOut, 1);
    expect_eq("R9 dummy holds first bit", hStateOut[0], 0);
    hshift(1'b0);
    expect_eq("R9 R8 inverted bit reaches stage 0", hStateOut[0], 1);
    hCapData = 3'b101;
    @(negedge clk);
    expect_eq("R2 hardened capture", hStateOut, 3'b101);
    expect_eq("R4 hardened output inverted", hScanOut, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_capture();
    test_step();
    test_equation();
    test_load();
    test_hardened();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule